// File: doc/BRIEF.md
# Indirect-access I/O interrupt redirection controller

This block takes 24 external interrupt lines and turns each event into a delivery request for a processor-side message formatter. Every line has its own programmable redirection entry. The entry sets the vector, the delivery mode, the destination mode, the polarity flag, the trigger style (edge or level), the mask and an 8-bit destination. A level entry also carries a remote-IRR flag that the block sets on its own.

Software reaches every register through two bus offsets. Offset 0x00 holds a select byte. Offset 0x10 is a data window onto whichever register the select byte names. Requests leave on a valid/ready stream. Once `dlv_valid` is high, the request and all its fields stay frozen until a cycle in which `dlv_ready` is also high. A request is committed when it is loaded into the output register: an edge entry loses its pending state at that point, and a level entry gains its remote-IRR flag. Back-pressure therefore never causes a duplicate request. A separate end-of-interrupt strobe carries a vector and releases level entries that have that vector.

Top module: `irq_router`

## Requirements
- R1: After reset, `dlv_valid` is 0, the select byte and ID are 0, and every entry reads 0x00010000 on its low dword (only mask set) and 0 on its high dword.
- R2: Only `bus_addr[7:0]` is decoded. Offset 0x00 writes and reads back the select byte in bits 7:0. Offset 0x10 is the data window. Any other offset reads 0 and ignores writes.
- R3: Select 0x00 is the ID: bits 27:24 are writable and read back there, and all other bits read 0. Select 0x01 reads 0x00170011. Select 0x02 reads 0. Writes to 0x01 and 0x02 change nothing. Selects 0x03–0x0F read 0.
- R4: Select 0x10+2n is the low dword of entry n and 0x10+2n+1 is its high dword, for n = 0..23. The low dword holds vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], remote IRR [14] (read-only), trigger [15] (1 = level) and mask [16]. Bit 12 reads 0. The high dword holds the destination in [31:24]. Selects 0x40 and above read 0 and ignore writes.
- R5: A low-dword write takes effect only when its bit 16 is 1 or its bits 7:0 lie in 0x10..0xFE. Any other write, including all zeros, leaves the entry unchanged.
- R6: On an edge entry, a rising pin sets the pending state, even while the entry is masked. One request is issued and the pending state is cleared. A table write that unmasks a pending entry leads to its delivery.
- R7: On a level entry, the pending state follows the pin. Issuing a request sets remote IRR. No further request for that pin is issued while remote IRR is set.
- R8: An `eoi_valid` pulse clears remote IRR on every level entry whose vector equals `eoi_vector`. A pulse with a different vector has no effect.
- R9: When several pins are eligible, the lowest-numbered pin is issued first. At most one request is issued per clock, and back-to-back requests go out on consecutive clocks while `dlv_ready` stays high.
- R10: While `dlv_valid` is high and `dlv_ready` is low, `dlv_valid` and every request field hold their values.
- R11: A masked entry never produces a request.
- R12: The request fields carry the issuing entry's vector, delivery mode, destination mode, trigger style and destination, plus the pin number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register address; low byte decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pins | input | 24 | External interrupt lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| dlv_ready | input | 1 | Downstream accepts the request |
| dlv_valid | output | 1 | Request available |
| dlv_vector | output | 8 | Request vector |
| dlv_mode | output | 3 | Delivery mode |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_level | output | 1 | 1 if the entry is level-triggered |
| dlv_dest | output | 8 | Destination |
| dlv_pin | output | 5 | Issuing pin number |

## Verification
The assertions check, on every cycle, that:
- a held request does not change under back-pressure;
- no request is issued for a masked pin or for a level pin that is waiting on remote IRR;
- a matching end-of-interrupt clears remote IRR;
- an issued edge pending state is gone on the next cycle;
- filtered writes and writes to the version or arbitration selects leave the register file untouched.

Only the bench scenarios can show the following: the order in which competing pins leave, redelivery after end-of-interrupt while a level pin stays high, delivery that results from unmasking a latched edge, and the readback values at each select.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       lvl;
    logic       pol;
    logic       dstmode;
    logic [2:0] dlvmode;
    logic [7:0] vec;
  } rte_t;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;
  localparam logic [7:0] VEC_LO  = 8'h10;
  localparam logic [7:0] VEC_HI  = 8'hFE;

  localparam rte_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, lvl: 1'b0, pol: 1'b0,
                                 dstmode: 1'b0, dlvmode: 3'd0, vec: 8'h00};

  function automatic logic [31:0] lo_word(rte_t e, logic rirr);
    return {15'd0, e.mask, e.lvl, rirr, e.pol, 1'b0, e.dstmode, e.dlvmode, e.vec};
  endfunction

  function automatic logic vec_ok(logic [31:0] w);
    return w[16] || (w[7:0] >= VEC_LO && w[7:0] <= VEC_HI);
  endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NPINS    = 24,
  parameter int ADDR_W   = 12,
  parameter int ID_W     = 4,
  parameter logic [7:0] VER_CODE = 8'h11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NPINS-1:0]       rirr,
  output rte_t [NPINS-1:0]       tbl
);
  localparam int IDX_W = $clog2(NPINS);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE};

  logic [7:0]      sel_q;
  logic [ID_W-1:0] id_q;
  rte_t [NPINS-1:0] tbl_q;

  logic [7:0]       off;
  logic [7:0]       rel;
  logic [6:0]       ent;
  logic [IDX_W-1:0] eidx;
  logic             hi, in_tbl, win_wr;

  assign off    = bus_addr[7:0];
  assign rel    = sel_q - SEL_TBL;
  assign ent    = rel[7:1];
  assign eidx   = ent[IDX_W-1:0];
  assign hi     = sel_q[0];
  assign in_tbl = (sel_q >= SEL_TBL) && (32'(ent) < NPINS);
  assign win_wr = bus_wr && (off == OFF_WIN);
  assign tbl    = tbl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 8'h00;
      id_q  <= '0;
    end else begin
      if (bus_wr && off == OFF_SEL) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == SEL_ID) id_q <= bus_wdata[24 +: ID_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= {NPINS{RTE_RESET}};
    end else if (win_wr && in_tbl) begin
      for (int i = 0; i < NPINS; i++) begin
        if (32'(ent) == i) begin
          if (hi) begin
            tbl_q[i].dest <= bus_wdata[31:24];
          end else if (vec_ok(bus_wdata)) begin
            tbl_q[i].vec     <= bus_wdata[7:0];
            tbl_q[i].dlvmode <= bus_wdata[10:8];
            tbl_q[i].dstmode <= bus_wdata[11];
            tbl_q[i].pol     <= bus_wdata[13];
            tbl_q[i].lvl     <= bus_wdata[15];
            tbl_q[i].mask    <= bus_wdata[16];
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (off == OFF_SEL) begin
      bus_rdata = {24'd0, sel_q};
    end else if (off == OFF_WIN) begin
      case (sel_q)
        SEL_ID:  bus_rdata[24 +: ID_W] = id_q;
        SEL_VER: bus_rdata = VER_WORD;
        SEL_ARB: bus_rdata = 32'd0;
        default: begin
          if (in_tbl) begin
            if (hi) bus_rdata = {tbl_q[eidx].dest, 24'd0};
            else    bus_rdata = lo_word(tbl_q[eidx], rirr[eidx]);
          end
        end
      endcase
    end
  end

  logic unused_regs;
  assign unused_regs = ^{bus_addr, bus_wdata[23:17], bus_wdata[14:12], ent};

  // R5: a filtered low-dword write leaves the table untouched
  assert_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && in_tbl && !hi && !vec_ok(bus_wdata)) |=> $stable(tbl_q));

  // R3: version and arbitration selects ignore writes
  assert_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && (sel_q == SEL_VER || sel_q == SEL_ARB))
      |=> ($stable(tbl_q) && $stable(id_q) && $stable(sel_q)));

endmodule

// File: rtl/irq_router_pins.sv
module irq_router_pins
  import irq_router_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  rte_t [NPINS-1:0] tbl,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  input  logic             issue_en,
  input  logic [IDX_W-1:0] issue_idx,
  output logic [NPINS-1:0] eligible,
  output logic [NPINS-1:0] rirr
);
  logic [NPINS-1:0] pin_q, pend_q, rirr_q;
  logic [NPINS-1:0] hit, eoi_hit, rise;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      hit[i]      = issue_en && (32'(issue_idx) == i);
      eoi_hit[i]  = eoi_valid && tbl[i].lvl && (eoi_vector == tbl[i].vec);
      rise[i]     = pins[i] && !pin_q[i];
      eligible[i] = pend_q[i] && !tbl[i].mask && !(tbl[i].lvl && rirr_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      pend_q <= '0;
      rirr_q <= '0;
    end else begin
      pin_q <= pins;
      for (int i = 0; i < NPINS; i++) begin
        if (tbl[i].lvl) pend_q[i] <= pins[i];
        else            pend_q[i] <= (pend_q[i] && !hit[i]) || rise[i];
        if (hit[i] && tbl[i].lvl) rirr_q[i] <= 1'b1;
        else if (eoi_hit[i])      rirr_q[i] <= 1'b0;
      end
    end
  end

  assign rirr = rirr_q;

  logic unused_pins;
  always_comb begin
    unused_pins = 1'b0;
    for (int i = 0; i < NPINS; i++)
      unused_pins = unused_pins ^ (^{tbl[i].dest, tbl[i].pol, tbl[i].dstmode, tbl[i].dlvmode});
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    // R7: a level pin awaiting end-of-interrupt is never issued
    assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl[g].lvl && rirr_q[g]) |-> !hit[g]);
    // R11: masked entries are skipped by the scanner
    assert_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tbl[g].mask |-> !hit[g]);
    // R8: matching end-of-interrupt releases the entry
    assert_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit[g] && !hit[g]) |=> !rirr_q[g]);
    // R6: an issued edge event is consumed
    assert_edge_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && !tbl[g].lvl && !rise[g]) |=> !pend_q[g]);
  end

endmodule

// File: rtl/irq_router_scan.sv
module irq_router_scan
  import irq_router_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] eligible,
  input  rte_t [NPINS-1:0] tbl,
  input  logic             dlv_ready,
  output logic             issue_en,
  output logic [IDX_W-1:0] issue_idx,
  output logic             dlv_valid,
  output logic [7:0]       dlv_vector,
  output logic [2:0]       dlv_mode,
  output logic             dlv_dest_mode,
  output logic             dlv_level,
  output logic [7:0]       dlv_dest,
  output logic [IDX_W-1:0] dlv_pin
);
  logic             found, free;
  logic [IDX_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  assign free      = !dlv_valid || dlv_ready;
  assign issue_en  = free && found;
  assign issue_idx = pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_valid     <= 1'b0;
      dlv_vector    <= 8'h00;
      dlv_mode      <= 3'd0;
      dlv_dest_mode <= 1'b0;
      dlv_level     <= 1'b0;
      dlv_dest      <= 8'h00;
      dlv_pin       <= '0;
    end else if (free) begin
      dlv_valid <= found;
      if (found) begin
        dlv_vector    <= tbl[pick].vec;
        dlv_mode      <= tbl[pick].dlvmode;
        dlv_dest_mode <= tbl[pick].dstmode;
        dlv_level     <= tbl[pick].lvl;
        dlv_dest      <= tbl[pick].dest;
        dlv_pin       <= pick;
      end
    end
  end

  logic unused_scan;
  always_comb begin
    unused_scan = 1'b0;
    for (int i = 0; i < NPINS; i++)
      unused_scan = unused_scan ^ tbl[i].pol ^ tbl[i].mask;
  end

  // R10: a stalled request holds every field
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid &&
      $stable({dlv_vector, dlv_mode, dlv_dest_mode, dlv_level, dlv_dest, dlv_pin})));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 12,
  parameter int ID_W   = 4,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  irq_pins,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  input  logic              dlv_ready,
  output logic              dlv_valid,
  output logic [7:0]        dlv_vector,
  output logic [2:0]        dlv_mode,
  output logic              dlv_dest_mode,
  output logic              dlv_level,
  output logic [7:0]        dlv_dest,
  output logic [IDX_W-1:0]  dlv_pin
);
  rte_t [NPINS-1:0] tbl;
  logic [NPINS-1:0] rirr, eligible;
  logic             issue_en;
  logic [IDX_W-1:0] issue_idx;

  irq_router_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rirr(rirr), .tbl(tbl));

  irq_router_pins #(.NPINS(NPINS)) u_pins (
    .clk(clk), .rst_n(rst_n), .pins(irq_pins), .tbl(tbl),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .issue_en(issue_en), .issue_idx(issue_idx),
    .eligible(eligible), .rirr(rirr));

  irq_router_scan #(.NPINS(NPINS)) u_scan (
    .clk(clk), .rst_n(rst_n), .eligible(eligible), .tbl(tbl),
    .dlv_ready(dlv_ready), .issue_en(issue_en), .issue_idx(issue_idx),
    .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_mode(dlv_mode),
    .dlv_dest_mode(dlv_dest_mode), .dlv_level(dlv_level),
    .dlv_dest(dlv_dest), .dlv_pin(dlv_pin));

endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pins = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        dlv_ready = 1'b1;
  logic        dlv_valid, dlv_dest_mode, dlv_level;
  logic [7:0]  dlv_vector, dlv_dest;
  logic [2:0]  dlv_mode;
  logic [4:0]  dlv_pin;

  irq_router uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pins(pins),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_ready(dlv_ready),
    .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_mode(dlv_mode),
    .dlv_dest_mode(dlv_dest_mode), .dlv_level(dlv_level),
    .dlv_dest(dlv_dest), .dlv_pin(dlv_pin));

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_vec[N];
  logic [2:0] m_dm[N];
  logic       m_dsm[N], m_pol[N], m_lvl[N], m_msk[N], m_rirr[N], m_pend[N], m_pinq[N];
  logic [7:0] m_dst[N];
  logic [7:0] m_sel;
  logic [3:0] m_id;
  logic       m_v, m_ods, m_ol;
  logic [7:0] m_ov, m_od;
  logic [2:0] m_om;
  int         m_op;

  always @(posedge clk) begin
    int pk;
    bit fr;
    bit hit;
    int e;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vec[i] = 0; m_dm[i] = 0; m_dsm[i] = 0; m_pol[i] = 0; m_lvl[i] = 0;
        m_msk[i] = 1; m_rirr[i] = 0; m_pend[i] = 0; m_pinq[i] = 0; m_dst[i] = 0;
      end
      m_sel = 0; m_id = 0; m_v = 0;
      m_ov = 0; m_om = 0; m_ods = 0; m_ol = 0; m_od = 0; m_op = 0;
    end else begin
      pk = -1;
      for (int i = 0; i < N; i++)
        if (pk < 0 && m_pend[i] && !m_msk[i] && !(m_lvl[i] && m_rirr[i])) pk = i;
      fr = !m_v || dlv_ready;
      if (fr) begin
        m_v = (pk >= 0);
        if (pk >= 0) begin
          m_ov = m_vec[pk]; m_om = m_dm[pk]; m_ods = m_dsm[pk];
          m_ol = m_lvl[pk]; m_od = m_dst[pk]; m_op = pk;
        end
      end
      for (int i = 0; i < N; i++) begin
        hit = fr && (pk == i);
        if (hit && m_lvl[i]) m_rirr[i] = 1;
        else if (eoi_valid && m_lvl[i] && eoi_vector == m_vec[i]) m_rirr[i] = 0;
        if (m_lvl[i]) m_pend[i] = pins[i];
        else m_pend[i] = (m_pend[i] && !hit) || (pins[i] && !m_pinq[i]);
        m_pinq[i] = pins[i];
      end
      if (bus_wr) begin
        if (bus_addr[7:0] == 8'h00) m_sel = bus_wdata[7:0];
        else if (bus_addr[7:0] == 8'h10) begin
          e = (int'(m_sel) - 16) / 2;
          if (m_sel == 8'h00) m_id = bus_wdata[27:24];
          else if (m_sel >= 8'h10 && e < N) begin
            if (m_sel[0]) m_dst[e] = bus_wdata[31:24];
            else if (bus_wdata[16] || (bus_wdata[7:0] >= 8'h10 && bus_wdata[7:0] <= 8'hFE)) begin
              m_vec[e] = bus_wdata[7:0]; m_dm[e] = bus_wdata[10:8]; m_dsm[e] = bus_wdata[11];
              m_pol[e] = bus_wdata[13]; m_lvl[e] = bus_wdata[15]; m_msk[e] = bus_wdata[16];
            end
          end
        end
      end
    end
  end

  // per-clock comparison of the request stream (R10, R12)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10 dlv_valid vs model", {31'd0, dlv_valid}, {31'd0, m_v});
      if (m_v)
        check("R12 request fields vs model",
              {6'd0, dlv_vector, dlv_mode, dlv_dest_mode, dlv_level, dlv_dest, dlv_pin},
              {6'd0, m_ov, m_om, m_ods, m_ol, m_od, 5'(m_op)});
    end
  end

  // handshake monitor
  int dcount[N];
  int cyc = 0;
  int hq[$];
  int hc[$];
  logic [7:0] last_vec, last_dest;
  initial for (int i = 0; i < N; i++) dcount[i] = 0;
  always @(posedge clk) begin
    cyc++;
    if (rst_n && dlv_valid && dlv_ready) begin
      dcount[dlv_pin]++;
      hq.push_back(int'(dlv_pin));
      hc.push_back(cyc);
      last_vec = dlv_vector;
      last_dest = dlv_dest;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic sel(input logic [7:0] s);
    wr(12'h000, {24'd0, s});
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 dlv_valid after reset", {31'd0, dlv_valid}, 32'd0);
    rd("R1 select after reset", 12'h000, 32'd0);
    rd("R1 ID after reset", 12'h010, 32'd0);
    sel(8'h10);
    rd("R1 entry0 low after reset", 12'h010, 32'h00010000);
    sel(8'h3F);
    rd("R1 entry23 high after reset", 12'h010, 32'd0);
    sel(8'h3E);
    rd("R1 entry23 low after reset", 12'h010, 32'h00010000);

    // R3 ID, version, arbitration
    sel(8'h00);
    wr(12'h010, 32'hFFFFFFFF);
    rd("R3 ID writable bits", 12'h010, 32'h0F000000);
    rd("R3 select unchanged by ID write", 12'h000, 32'd0);
    sel(8'h01);
    rd("R3 version", 12'h010, 32'h00170011);
    wr(12'h010, 32'h12345678);
    rd("R3 version after write", 12'h010, 32'h00170011);
    sel(8'h02);
    rd("R3 arbitration", 12'h010, 32'd0);
    wr(12'h010, 32'hFFFFFFFF);
    rd("R3 arbitration after write", 12'h010, 32'd0);
    sel(8'h00);
    rd("R3 ID kept after read-only writes", 12'h010, 32'h0F000000);

    // R2 address decode
    wr(12'h100, 32'h00000005);
    rd("R2 select via aliased address", 12'h000, 32'h00000005);
    rd("R2 reserved select reads zero", 12'h110, 32'd0);
    rd("R2 other offset reads zero", 12'h020, 32'd0);
    wr(12'h020, 32'h00000011);
    rd("R2 other offset write ignored", 12'h000, 32'h00000005);
    wr(12'hF00, 32'h00000000);
    rd("R2 window via aliased address", 12'hA10, 32'h0F000000);

    // R5 write filter, R4 layout
    sel(8'h12);
    wr(12'h010, 32'h00000000);
    rd("R5 all-zero write ignored", 12'h010, 32'h00010000);
    wr(12'h010, 32'h0000000F);
    rd("R5 low vector ignored", 12'h010, 32'h00010000);
    wr(12'h010, 32'h000000FF);
    rd("R5 vector FF ignored", 12'h010, 32'h00010000);
    wr(12'h010, 32'h00015B05);
    rd("R4 masked write accepted, bits 12 and 14 read-only", 12'h010, 32'h00010B05);
    wr(12'h010, 32'h00002010);
    rd("R5 vector 10 accepted", 12'h010, 32'h00002010);
    wr(12'h010, 32'h000000FE);
    rd("R5 vector FE accepted", 12'h010, 32'h000000FE);
    wr(12'h010, 32'h00010000);
    rd("R5 masked zero accepted", 12'h010, 32'h00010000);
    sel(8'h13);
    wr(12'h010, 32'hAB123456);
    rd("R4 high dword destination", 12'h010, 32'hAB000000);
    sel(8'h40);
    wr(12'h010, 32'hFFFFFFFF);
    rd("R4 select past table reads zero", 12'h010, 32'd0);
    sel(8'h10);
    rd("R4 entry0 untouched by out-of-range write", 12'h010, 32'h00010000);

    // R6 edge entry 3
    sel(8'h17);
    wr(12'h010, 32'h33000000);
    sel(8'h16);
    wr(12'h010, 32'h00000943);
    pins[3] = 1'b1;
    idle(6);
    check("R6 one request per rising edge", dcount[3], 1);
    check("R12 delivered vector", {24'd0, last_vec}, 32'h43);
    check("R12 delivered destination", {24'd0, last_dest}, 32'h33);
    pins[3] = 1'b0;
    idle(2);
    pins[3] = 1'b1;
    idle(4);
    check("R6 second rising edge", dcount[3], 2);
    pins[3] = 1'b0;

    // R11 masked entry, R6 unmask rescan
    sel(8'h18);
    wr(12'h010, 32'h00010044);
    pins[4] = 1'b1;
    idle(6);
    check("R11 masked entry not delivered", dcount[4], 0);
    pins[4] = 1'b0;
    wr(12'h010, 32'h00000044);
    idle(4);
    check("R6 latched edge delivered after unmask", dcount[4], 1);

    // R7 level entry 5, R8 end-of-interrupt
    sel(8'h1A);
    wr(12'h010, 32'h00008055);
    pins[5] = 1'b1;
    idle(6);
    check("R7 level delivered once", dcount[5], 1);
    rd("R7 remote IRR visible", 12'h010, 32'h0000C055);
    idle(5);
    check("R7 blocked while remote IRR set", dcount[5], 1);
    eoi(8'h56);
    idle(4);
    check("R8 non-matching EOI no effect", dcount[5], 1);
    rd("R8 remote IRR kept", 12'h010, 32'h0000C055);
    eoi(8'h55);
    idle(4);
    check("R8 matching EOI redelivers held level", dcount[5], 2);
    pins[5] = 1'b0;
    idle(2);
    eoi(8'h55);
    idle(3);
    rd("R8 remote IRR cleared", 12'h010, 32'h00008055);
    check("R8 no delivery with pin low", dcount[5], 2);

    // R9 ordering, R10 back-pressure
    sel(8'h1C); wr(12'h010, 32'h00000066);
    sel(8'h1E); wr(12'h010, 32'h00000067);
    sel(8'h20); wr(12'h010, 32'h00000068);
    @(negedge clk);
    dlv_ready = 1'b0;
    hq.delete();
    hc.delete();
    pins[8] = 1'b1; pins[6] = 1'b1; pins[7] = 1'b1;
    idle(6);
    check("R10 request held under back-pressure", {31'd0, dlv_valid}, 32'd1);
    check("R9 lowest pin offered first", {27'd0, dlv_pin}, 32'd6);
    dlv_ready = 1'b1;
    idle(6);
    check("R9 three requests", hq.size(), 3);
    if (hq.size() == 3) begin
      check("R9 order first", hq[0], 6);
      check("R9 order second", hq[1], 7);
      check("R9 order third", hq[2], 8);
      check("R9 consecutive clocks a", hc[1] - hc[0], 1);
      check("R9 consecutive clocks b", hc[2] - hc[1], 1);
    end
    idle(2);
    finish_run();
  end

endmodule